// File: doc/BRIEF.md
# Boot Source Selection Controller

This block sequences the power-up of a USB device that has an embedded CPU. When reset is released it fetches the first byte of an external serial EEPROM through a simple byte-read request port. The serial bus transaction sits behind that port. The block then combines that signature byte with an external boot pin to choose one of four firmware sources:

- a built-in default device;
- firmware downloaded by the host;
- firmware copied out of the EEPROM;
- an external parallel code memory.

The block keeps the CPU in reset while the built-in hardware core handles enumeration. It owns the re-enumeration flag, which selects whether the hardware core (flag 0) or the CPU (flag 1) answers endpoint-zero requests. In EEPROM-load mode it streams the EEPROM payload into program RAM. Only after the last byte has been written does it release the CPU and set the flag.

After the sequence ends, firmware can write three controls:

- the CPU-reset bit;
- a sticky set of the re-enumeration flag;
- the attach pull-up control. Driving the pull-up signals attachment, and releasing it signals removal, so toggling it forces the host to enumerate again.

The sequencer states are:

| State | Role |
|---|---|
| ST_SIG_REQ | request the byte at offset 0 |
| ST_SIG_WAIT | wait for it |
| ST_ID_REQ | request an identity byte at offset 1 + index |
| ST_ID_WAIT | wait for it |
| ST_LEN_REQ | request a length byte at offset 7 + index |
| ST_LEN_WAIT | wait for it |
| ST_COPY_REQ | request a payload byte at offset 9 + index |
| ST_COPY_WAIT | wait for it |
| ST_RELEASE | hand the CPU over |
| ST_DONE | terminal |

The transitions are:

| From | Condition | To |
|---|---|---|
| each REQ state | always | its WAIT state |
| ST_SIG_WAIT | byte is C0h or C2h | ST_ID_REQ |
| ST_SIG_WAIT | any other byte, or timeout | ST_DONE |
| ST_ID_WAIT | byte 6 read, EEPROM-load mode | ST_LEN_REQ |
| ST_ID_WAIT | byte 6 read, host-load mode | ST_DONE |
| ST_ID_WAIT | fewer than 6 bytes read | ST_ID_REQ |
| ST_LEN_WAIT | second byte read, length 0 | ST_RELEASE |
| ST_LEN_WAIT | second byte read, length nonzero | ST_COPY_REQ |
| ST_LEN_WAIT | first byte read | ST_LEN_REQ |
| ST_COPY_WAIT | last byte read | ST_RELEASE |
| ST_COPY_WAIT | more bytes to read | ST_COPY_REQ |
| ST_RELEASE | always | ST_DONE |
| any WAIT state | timeout | ST_DONE, with the mode chosen by the pin |

Top module: `boot_src_ctrl`

## Requirements
- R1: While reset is asserted and until the sequence ends, `cpu_hold` is 1, `renum` is 0, `attach_pull` is 1 after reset, `boot_done` is 0 and `ram_we` is 0. The first read request is made at EEPROM offset 0.
- R2: A signature byte of C0h selects host-load mode (`boot_mode` = 01) whatever the pin level. The controller reads offsets 1..6 as little-endian pairs: vendor ID at offsets 1-2, product ID at 3-4, release at 5-6, with the low byte first. At the end `cpu_hold` stays 1 and `renum` stays 0.
- R3: A signature byte of C2h selects EEPROM-load mode (`boot_mode` = 10) whatever the pin level. The controller reads the identity bytes, then a 16-bit length at offsets 7 (low) and 8 (high). It then writes EEPROM byte 9+i to RAM address i for i = 0 .. length-1, in ascending order, with one write per `ram_we` pulse.
- R4: In EEPROM-load mode, `cpu_hold` falls, `renum` rises and `boot_done` rises on the same clock edge. That edge is the one after the edge that raised the last `ram_we` pulse. A length of 0 produces no RAM write and still releases the CPU.
- R5: If the signature is neither C0h nor C2h, the pin selects the mode. Pin low gives default mode (00) with `cpu_hold` kept at 1. Pin high gives external-memory mode (11), with `cpu_hold` released as `boot_done` rises. In both cases `renum` stays 0.
- R6: A read that gets no `rd_ack` within TMO_CYC cycles of its request counts as no EEPROM present, and the R5 pin rule applies. `boot_done` rises no earlier than TMO_CYC cycles after reset release.
- R7: `fw_hold_we` is ignored before `boot_done`. After it, `cpu_hold` takes `fw_hold_val` one clock edge after the write, and no other output changes.
- R8: `fw_renum_set` is ignored before `boot_done`. After it, the pulse sets `renum` to 1, and `renum` then stays 1 until reset.
- R9: `fw_attach_we` loads `attach_pull` with `fw_attach_val` at any time, so firmware can release and re-drive the pull-up.
- R10: Once `boot_done` is 1 it stays 1, and `boot_mode` no longer changes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| ext_boot_pin | input | 1 | external-access boot pin, used when no valid signature |
| rd_req | output | 1 | EEPROM byte-read request, held until ack or timeout |
| rd_addr | output | AW | EEPROM byte offset of the pending request |
| rd_ack | input | 1 | one-cycle acknowledge carrying read data |
| rd_data | input | 8 | EEPROM byte, valid with rd_ack |
| ram_we | output | 1 | program RAM write strobe |
| ram_addr | output | AW | program RAM byte address |
| ram_wdata | output | 8 | program RAM write data |
| fw_hold_we | input | 1 | firmware write of the CPU-reset bit |
| fw_hold_val | input | 1 | value for the CPU-reset bit |
| fw_renum_set | input | 1 | firmware pulse setting the re-enumeration flag |
| fw_attach_we | input | 1 | firmware write of the attach control |
| fw_attach_val | input | 1 | value for the attach control |
| cpu_hold | output | 1 | CPU held in reset when 1 |
| renum | output | 1 | 0: hardware core answers endpoint zero, 1: CPU does |
| attach_pull | output | 1 | 1 drives the D+ pull-up (attached), 0 releases it |
| boot_done | output | 1 | boot sequence finished |
| boot_mode | output | 2 | 00 default, 01 host-load, 10 EEPROM-load, 11 external memory |
| vid | output | 16 | vendor ID read from EEPROM |
| pid | output | 16 | product ID read from EEPROM |
| rel | output | 16 | release number read from EEPROM |

## Verification
The selection is tried with:

- each signature crossed with both pin levels, which separates "signature wins over pin" from "pin decides";
- a non-signature byte against an absent device, which separates a decoded mismatch from the timeout path;
- EEPROM-load with lengths 0, 1, 5 and 33, which separates the empty copy from single-byte and multi-byte ordering, and tests that the release lands exactly one edge after the final write.

Firmware writes are issued both during the sequence and after it, to show the gating of the CPU-reset bit and the re-enumeration flag. The attach control is toggled both ways.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;

    typedef enum logic [1:0] {
        MODE_DFLT   = 2'b00,
        MODE_HOST   = 2'b01,
        MODE_EEPROM = 2'b10,
        MODE_EXTMEM = 2'b11
    } boot_mode_e;

    typedef enum logic [3:0] {
        ST_SIG_REQ,
        ST_SIG_WAIT,
        ST_ID_REQ,
        ST_ID_WAIT,
        ST_LEN_REQ,
        ST_LEN_WAIT,
        ST_COPY_REQ,
        ST_COPY_WAIT,
        ST_RELEASE,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] SIG_HOST   = 8'hC0;
    localparam logic [7:0] SIG_EEPROM = 8'hC2;

    localparam int ID_BASE      = 1;
    localparam int ID_BYTES     = 6;
    localparam int LEN_BASE     = 7;
    localparam int PAYLOAD_BASE = 9;
    localparam int LEN_W        = 16;

endpackage

// File: rtl/boot_rd_port.sv
module boot_rd_port #(
    parameter int AW      = 16,
    parameter int TMO_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          got,
    output logic          tmo,
    output logic [7:0]    data
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic          busy;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            addr_q <= '0;
            cnt    <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            addr_q <= addr;
            cnt    <= '0;
        end else if (busy) begin
            if (got || tmo) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign got     = busy & rd_ack;
    assign tmo     = busy & ~rd_ack & (cnt == CW'(TMO_CYC - 1));
    assign data    = rd_data;
    assign rd_req  = busy;
    assign rd_addr = addr_q;

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_src_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_pin,
    input  logic          got,
    input  logic          tmo,
    input  logic [7:0]    data,
    output logic          rd_start,
    output logic [AW-1:0] rd_addr,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          seq_release,
    output logic          seq_renum,
    output logic          boot_done,
    output boot_mode_e    boot_mode,
    output logic [15:0]   vid,
    output logic [15:0]   pid,
    output logic [15:0]   rel
);
    seq_state_e             state, nxt;
    boot_mode_e             mode_q;
    logic [LEN_W-1:0]       idx;
    logic [LEN_W-1:0]       len;
    logic [8*ID_BYTES-1:0]  id_q;
    logic                   sig_hit;
    logic                   fallback_now;
    boot_mode_e             fb_mode;

    assign sig_hit = (data == SIG_HOST) || (data == SIG_EEPROM);
    assign fb_mode = ext_pin ? MODE_EXTMEM : MODE_DFLT;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SIG_REQ;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SIG_REQ:  nxt = ST_SIG_WAIT;
            ST_SIG_WAIT: begin
                if (got) begin
                    nxt = sig_hit ? ST_ID_REQ : ST_DONE;
                end else if (tmo) begin
                    nxt = ST_DONE;
                end
            end
            ST_ID_REQ:   nxt = ST_ID_WAIT;
            ST_ID_WAIT: begin
                if (got) begin
                    if (idx == LEN_W'(ID_BYTES - 1)) begin
                        nxt = (mode_q == MODE_EEPROM) ? ST_LEN_REQ : ST_DONE;
                    end else begin
                        nxt = ST_ID_REQ;
                    end
                end else if (tmo) begin
                    nxt = ST_DONE;
                end
            end
            ST_LEN_REQ:  nxt = ST_LEN_WAIT;
            ST_LEN_WAIT: begin
                if (got) begin
                    if (idx == LEN_W'(1)) begin
                        nxt = ({data, len[7:0]} == '0) ? ST_RELEASE : ST_COPY_REQ;
                    end else begin
                        nxt = ST_LEN_REQ;
                    end
                end else if (tmo) begin
                    nxt = ST_DONE;
                end
            end
            ST_COPY_REQ: nxt = ST_COPY_WAIT;
            ST_COPY_WAIT: begin
                if (got) begin
                    nxt = (idx == len - 1'b1) ? ST_RELEASE : ST_COPY_REQ;
                end else if (tmo) begin
                    nxt = ST_DONE;
                end
            end
            ST_RELEASE:  nxt = ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            default:     nxt = ST_DONE;
        endcase
    end

    // read request issue
    assign rd_start = (state == ST_SIG_REQ) || (state == ST_ID_REQ) ||
                      (state == ST_LEN_REQ) || (state == ST_COPY_REQ);

    always_comb begin
        rd_addr = '0;
        unique case (state)
            ST_ID_REQ:   rd_addr = AW'(ID_BASE) + AW'(idx);
            ST_LEN_REQ:  rd_addr = AW'(LEN_BASE) + AW'(idx);
            ST_COPY_REQ: rd_addr = AW'(PAYLOAD_BASE) + AW'(idx);
            default:     rd_addr = '0;
        endcase
    end

    // hand-over strobes to the control registers
    assign fallback_now = ((state == ST_SIG_WAIT) && ((got && !sig_hit) || tmo)) ||
                          (((state == ST_ID_WAIT) || (state == ST_LEN_WAIT) ||
                            (state == ST_COPY_WAIT)) && tmo);
    assign seq_release  = (state == ST_RELEASE) || (fallback_now && ext_pin);
    assign seq_renum    = (state == ST_RELEASE);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_DFLT;
            boot_done <= 1'b0;
            idx       <= '0;
            len       <= '0;
            id_q      <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we    <= 1'b0;
            boot_done <= (nxt == ST_DONE);
            unique case (state)
                ST_SIG_WAIT: begin
                    if (got) begin
                        idx <= '0;
                        if (data == SIG_HOST) begin
                            mode_q <= MODE_HOST;
                        end else if (data == SIG_EEPROM) begin
                            mode_q <= MODE_EEPROM;
                        end else begin
                            mode_q <= fb_mode;
                        end
                    end else if (tmo) begin
                        mode_q <= fb_mode;
                    end
                end
                ST_ID_WAIT: begin
                    if (got) begin
                        id_q <= {data, id_q[8*ID_BYTES-1:8]};
                        idx  <= (idx == LEN_W'(ID_BYTES - 1)) ? '0 : idx + 1'b1;
                    end else if (tmo) begin
                        mode_q <= fb_mode;
                    end
                end
                ST_LEN_WAIT: begin
                    if (got) begin
                        if (idx == '0) begin
                            len[7:0] <= data;
                            idx      <= LEN_W'(1);
                        end else begin
                            len[15:8] <= data;
                            idx       <= '0;
                        end
                    end else if (tmo) begin
                        mode_q <= fb_mode;
                    end
                end
                ST_COPY_WAIT: begin
                    if (got) begin
                        ram_we    <= 1'b1;
                        ram_addr  <= AW'(idx);
                        ram_wdata <= data;
                        idx       <= idx + 1'b1;
                    end else if (tmo) begin
                        mode_q <= fb_mode;
                    end
                end
                default: ;
            endcase
        end
    end

    assign boot_mode = mode_q;
    assign vid       = id_q[15:0];
    assign pid       = id_q[31:16];
    assign rel       = id_q[47:32];

endmodule

// File: rtl/boot_ctl_regs.sv
module boot_ctl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_done,
    input  logic seq_release,
    input  logic seq_renum,
    input  logic fw_hold_we,
    input  logic fw_hold_val,
    input  logic fw_renum_set,
    input  logic fw_attach_we,
    input  logic fw_attach_val,
    output logic cpu_hold,
    output logic renum,
    output logic attach_pull
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_hold    <= 1'b1;
            renum       <= 1'b0;
            attach_pull <= 1'b1;
        end else begin
            if (seq_release) begin
                cpu_hold <= 1'b0;
            end else if (boot_done && fw_hold_we) begin
                cpu_hold <= fw_hold_val;
            end
            if (seq_renum || (boot_done && fw_renum_set)) begin
                renum <= 1'b1;
            end
            if (fw_attach_we) begin
                attach_pull <= fw_attach_val;
            end
        end
    end

endmodule

// File: rtl/boot_src_ctrl.sv
module boot_src_ctrl
    import boot_src_pkg::*;
#(
    parameter int AW      = 16,
    parameter int TMO_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_boot_pin,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    input  logic          fw_hold_we,
    input  logic          fw_hold_val,
    input  logic          fw_renum_set,
    input  logic          fw_attach_we,
    input  logic          fw_attach_val,
    output logic          cpu_hold,
    output logic          renum,
    output logic          attach_pull,
    output logic          boot_done,
    output logic [1:0]    boot_mode,
    output logic [15:0]   vid,
    output logic [15:0]   pid,
    output logic [15:0]   rel
);
    logic          rd_start;
    logic [AW-1:0] req_addr;
    logic          got;
    logic          tmo;
    logic [7:0]    rdata;
    logic          seq_release;
    logic          seq_renum;
    boot_mode_e    mode_e;

    boot_rd_port #(.AW(AW), .TMO_CYC(TMO_CYC)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_start),
        .addr    (req_addr),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .got     (got),
        .tmo     (tmo),
        .data    (rdata)
    );

    boot_seq_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin     (ext_boot_pin),
        .got         (got),
        .tmo         (tmo),
        .data        (rdata),
        .rd_start    (rd_start),
        .rd_addr     (req_addr),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .seq_release (seq_release),
        .seq_renum   (seq_renum),
        .boot_done   (boot_done),
        .boot_mode   (mode_e),
        .vid         (vid),
        .pid         (pid),
        .rel         (rel)
    );

    boot_ctl_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_done     (boot_done),
        .seq_release   (seq_release),
        .seq_renum     (seq_renum),
        .fw_hold_we    (fw_hold_we),
        .fw_hold_val   (fw_hold_val),
        .fw_renum_set  (fw_renum_set),
        .fw_attach_we  (fw_attach_we),
        .fw_attach_val (fw_attach_val),
        .cpu_hold      (cpu_hold),
        .renum         (renum),
        .attach_pull   (attach_pull)
    );

    assign boot_mode = mode_e;

endmodule

// File: rtl/boot_src_ctrl_chk.sv
module boot_src_ctrl_chk
    import boot_src_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          ram_we,
    input logic          cpu_hold,
    input logic          renum,
    input logic          boot_done,
    input logic [1:0]    boot_mode
);
    a_r1_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> cpu_hold);

    a_r1_renum_low_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> !renum);

    a_r1_req_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (!rd_req || $stable(rd_addr)));

    a_r3_write_only_eeprom_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (boot_mode == MODE_EEPROM));

    a_r3_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    a_r4_renum_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(renum) |-> boot_done);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (boot_done && $stable(boot_mode)));

endmodule

bind boot_src_ctrl boot_src_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_addr   (rd_addr),
    .ram_we    (ram_we),
    .cpu_hold  (cpu_hold),
    .renum     (renum),
    .boot_done (boot_done),
    .boot_mode (boot_mode)
);

// File: tb/boot_src_ctrl_tb.sv
module boot_src_ctrl_tb;
    localparam int AW  = 16;
    localparam int TMO = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_boot_pin = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          fw_hold_we = 1'b0, fw_hold_val = 1'b0, fw_renum_set = 1'b0;
    logic          fw_attach_we = 1'b0, fw_attach_val = 1'b0;
    logic          cpu_hold, renum, attach_pull, boot_done;
    logic [1:0]    boot_mode;
    logic [15:0]   vid, pid, rel;

    int checks = 0;
    int errors = 0;

    logic [7:0] ee [0:511];
    bit         ee_present = 1'b1;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } wr_t;
    wr_t exp_q[$];

    always #2 clk = ~clk;

    boot_src_ctrl #(.AW(AW), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_boot_pin(ext_boot_pin),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .fw_hold_we(fw_hold_we), .fw_hold_val(fw_hold_val),
        .fw_renum_set(fw_renum_set), .fw_attach_we(fw_attach_we),
        .fw_attach_val(fw_attach_val), .cpu_hold(cpu_hold), .renum(renum),
        .attach_pull(attach_pull), .boot_done(boot_done), .boot_mode(boot_mode),
        .vid(vid), .pid(pid), .rel(rel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM model: answers a held request after two cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && ee_present && rst_n) begin
                repeat (2) @(negedge clk);
                rd_ack  = 1'b1;
                rd_data = ee[rd_addr[8:0]];
                @(negedge clk);
                rd_ack  = 1'b0;
            end
        end
    end

    // scoreboard monitor for RAM writes (R3)
    initial begin
        forever begin
            @(negedge clk);
            if (ram_we) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected RAM write", {8'h0, ram_addr, ram_wdata}, 32'hFFFF_FFFF);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    chk("R3 RAM write addr/data", {8'h0, ram_addr, ram_wdata}, {8'h0, e.a, e.d});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int   run_cycles;
    logic prev_we;

    // driver: builds EEPROM image, pushes expected writes, runs one boot
    task automatic run_boot(input logic [7:0] sig, input bit pin, input bit present,
                            input int len, input bit early_fw);
        for (int i = 0; i < 512; i++) ee[i] = 8'(i * 7 + 3);
        ee[0] = sig;
        ee[1] = 8'h34; ee[2] = 8'h12;
        ee[3] = 8'hCD; ee[4] = 8'hAB;
        ee[5] = 8'h01; ee[6] = 8'h02;
        ee[7] = len[7:0]; ee[8] = len[15:8];
        if (present && sig == 8'hC2) begin
            for (int i = 0; i < len; i++) exp_q.push_back({16'(i), ee[9 + i]});
        end
        @(negedge clk);
        rst_n        = 1'b0;
        ext_boot_pin = pin;
        ee_present   = present;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        if (early_fw) begin
            fw_hold_we = 1'b1; fw_hold_val = 1'b0; fw_renum_set = 1'b1;
            @(negedge clk);
            fw_hold_we = 1'b0; fw_renum_set = 1'b0;
        end
        run_cycles = 0;
        prev_we    = 1'b0;
        while (1) begin
            @(negedge clk);
            run_cycles++;
            if (boot_done || run_cycles > 5000) break;
            prev_we = ram_we;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 hold in reset", cpu_hold, 1);
        chk("R1 renum in reset", renum, 0);
        chk("R1 attach in reset", attach_pull, 1);
        chk("R1 done in reset", boot_done, 0);
        chk("R1 ram_we in reset", ram_we, 0);
        ee_present = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 first request", rd_req, 1);
        chk("R1 first offset", rd_addr, 0);

        // R2 with early firmware writes (R7, R8 ignored before done)
        run_boot(8'hC0, 1'b0, 1'b1, 0, 1'b1);
        chk("R2 mode host", boot_mode, 2'b01);
        chk("R2 vid", vid, 16'h1234);
        chk("R2 pid", pid, 16'hABCD);
        chk("R2 rel", rel, 16'h0201);
        chk("R2/R7 hold kept", cpu_hold, 1);
        chk("R2/R8 renum kept", renum, 0);

        // R7, R8, R9 after done
        fw_hold_we = 1'b1; fw_hold_val = 1'b0;
        @(negedge clk);
        fw_hold_we = 1'b0;
        chk("R7 hold written", cpu_hold, 0);
        chk("R7 renum untouched", renum, 0);
        chk("R7 attach untouched", attach_pull, 1);
        fw_renum_set = 1'b1;
        @(negedge clk);
        fw_renum_set = 1'b0;
        chk("R8 renum set", renum, 1);
        repeat (3) @(negedge clk);
        chk("R8 renum sticky", renum, 1);
        chk("R10 done sticky", boot_done, 1);
        chk("R10 mode stable", boot_mode, 2'b01);
        fw_attach_we = 1'b1; fw_attach_val = 1'b0;
        @(negedge clk);
        chk("R9 attach released", attach_pull, 0);
        fw_attach_val = 1'b1;
        @(negedge clk);
        fw_attach_we = 1'b0;
        chk("R9 attach driven", attach_pull, 1);

        // R2: signature wins over pin high
        run_boot(8'hC0, 1'b1, 1'b1, 0, 1'b0);
        chk("R2 host with pin high", boot_mode, 2'b01);
        chk("R2 hold with pin high", cpu_hold, 1);

        // R3/R4: EEPROM load, length 5, pin high
        run_boot(8'hC2, 1'b1, 1'b1, 5, 1'b0);
        chk("R3 mode eeprom", boot_mode, 2'b10);
        chk("R3 vid", vid, 16'h1234);
        chk("R4 last write one edge before done", prev_we, 1);
        chk("R4 hold released", cpu_hold, 0);
        chk("R4 renum set", renum, 1);
        @(negedge clk);
        chk("R3 all writes seen", exp_q.size(), 0);

        // R4: zero length
        run_boot(8'hC2, 1'b0, 1'b1, 0, 1'b0);
        chk("R4 zero len mode", boot_mode, 2'b10);
        chk("R4 zero len hold", cpu_hold, 0);
        chk("R4 zero len renum", renum, 1);

        // R3: one byte and 33 bytes
        run_boot(8'hC2, 1'b0, 1'b1, 1, 1'b0);
        chk("R4 single write before done", prev_we, 1);
        @(negedge clk);
        chk("R3 single write seen", exp_q.size(), 0);
        run_boot(8'hC2, 1'b0, 1'b1, 33, 1'b0);
        chk("R4 long copy release", cpu_hold, 0);
        @(negedge clk);
        chk("R3 long copy all seen", exp_q.size(), 0);

        // R5: non-signature byte
        run_boot(8'h55, 1'b0, 1'b1, 0, 1'b0);
        chk("R5 default mode", boot_mode, 2'b00);
        chk("R5 default hold", cpu_hold, 1);
        chk("R5 default renum", renum, 0);
        run_boot(8'hC1, 1'b1, 1'b1, 0, 1'b0);
        chk("R5 extmem mode", boot_mode, 2'b11);
        chk("R5 extmem hold released", cpu_hold, 0);
        chk("R5 extmem renum", renum, 0);

        // R6: absent device
        run_boot(8'hC2, 1'b1, 1'b0, 4, 1'b0);
        chk("R6 absent pin high mode", boot_mode, 2'b11);
        chk("R6 no early finish", (run_cycles >= TMO) ? 1 : 0, 1);
        chk("R6 bounded finish", (run_cycles <= TMO + 8) ? 1 : 0, 1);
        chk("R6 absent hold", cpu_hold, 0);
        run_boot(8'hC0, 1'b0, 1'b0, 0, 1'b0);
        chk("R6 absent pin low mode", boot_mode, 2'b00);
        chk("R6 absent pin low hold", cpu_hold, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule